// File: doc/BRIEF.md
# Bitstream Header Clock-to-Data Ratio Detector

This block sits on the path that carries a configuration image, one 32-bit word per valid beat, toward a data register. While the words pass through, it counts them from the start of the image. It takes the encryption field from one fixed header word and the compression flag from a later fixed header word. When the later word arrives, it combines the two flags with the selected configuration port width and produces a 2-bit code for the ratio between configuration clock and data.

The code and its valid flag hold until the next start-of-image pulse. If the stream ends before the compression word has been seen, the block raises a header error instead of a result. Each word is passed on one cycle later. When the last beat carries fewer than four bytes, the unused upper bytes are forced to zero. Decryption, decompression and integrity checking belong elsewhere.

Top module: `hdr_ratio_detect`

## Requirements
- R1: After reset or a start pulse, beats are numbered from 0. Word 69 sets the encrypted flag when its bits [3:2] are anything other than 2'b00.
- R2: Word 229 sets the compressed flag when its bit 1 is 0.
- R3: The ratio code is 0 when the image is neither encrypted nor compressed, whatever the width select.
- R4: Width select 1 means a 32-bit port and 0 means a 16-bit port; it is sampled with word 229. The code is 2 for a compressed image and 1 for an image that is encrypted but not compressed, plus one when the port is 32 bits wide.
- R5: The ratio code, the two flag outputs and the result-valid flag appear in the cycle after the word-229 beat. Before that beat the result-valid flag is 0. All of them then hold, even if the width select changes, until the next start pulse.
- R6: A last beat whose index is below 229 sets the header error, which holds until the next start pulse. That image then never produces a valid result.
- R7: A start pulse clears the result-valid flag, the header error and the word count, so the next beat is word 0 of a new image.
- R8: Every input beat appears on the output one cycle later. Full words are unchanged, and the output valid is low in cycles that follow no input beat.
- R9: On a last beat, a byte count of 3, 2 or 1 keeps only the low 3, 2 or 1 bytes (masks 0x00ffffff, 0x0000ffff, 0x000000ff). A count of 0 means a full word.
- R10: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sop_i | input | 1 | Start-of-image pulse |
| wide_i | input | 1 | Port width select: 1 = 32-bit, 0 = 16-bit |
| in_valid | input | 1 | Input beat valid |
| in_data | input | 32 | Input image word |
| in_last | input | 1 | Marks the final beat of the image |
| in_bytes | input | 2 | Valid bytes in the final beat, 0 = all four |
| out_valid | output | 1 | Output beat valid |
| out_data | output | 32 | Output word, tail bytes masked |
| ratio_o | output | 2 | Clock-to-data ratio code |
| ratio_valid_o | output | 1 | Ratio code is valid |
| encrypted_o | output | 1 | Image found encrypted |
| compressed_o | output | 1 | Image found compressed |
| hdr_err_o | output | 1 | Image ended before the header was complete |

## Verification
The hardest situation to reach is a start pulse that arrives partway through a header that is already counting. A stale count or a stale encryption capture would then give a wrong ratio for the next image without any visible error. The bench streams 150 words whose word 69 is marked encrypted and abandons them. It then pulses start and sends a plain, uncompressed image. It expects code 0 with both flags clear. The bench also ends an image exactly one word short of the compression word, to hit the edge of the header-error window.

// File: rtl/hdr_pkg.sv
package hdr_pkg;

  // Ratio code: 0 for a plain image, otherwise a base of 2 (compressed)
  // or 1 (encrypted only), plus one for the wide port.
  function automatic logic [1:0] ratio_code(input logic enc, input logic cmp,
                                            input logic wide);
    logic [1:0] base;
    if (!enc && !cmp) begin
      ratio_code = 2'd0;
    end else begin
      base = cmp ? 2'd2 : 2'd1;
      ratio_code = base + {1'b0, wide};
    end
  endfunction

  // Keep-mask for a word holding nbytes valid bytes (0 = full word).
  function automatic logic [31:0] tail_mask(input logic [1:0] nbytes);
    case (nbytes)
      2'd1:    tail_mask = 32'h0000_00ff;
      2'd2:    tail_mask = 32'h0000_ffff;
      2'd3:    tail_mask = 32'h00ff_ffff;
      default: tail_mask = 32'hffff_ffff;
    endcase
  endfunction

endpackage

// File: rtl/hdr_beat_counter.sv
module hdr_beat_counter #(
  parameter int LIMIT = 230,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sop_i,
  input  logic          beat_i,
  output logic [CW-1:0] idx_o
);
  logic [CW-1:0] cnt;
  logic          at_limit;

  assign at_limit = (cnt == CW'(LIMIT));
  assign idx_o    = sop_i ? '0 : cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (sop_i)                cnt <= beat_i ? CW'(1) : '0;
    else if (beat_i && !at_limit)  cnt <= cnt + CW'(1);
  end

  // R1: the count saturates and never passes the limit
  assert_cnt_bounded_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(LIMIT));
  // R7: a start pulse without a beat restarts numbering at word 0
  assert_sop_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sop_i && !beat_i) |=> (cnt == '0));

endmodule

// File: rtl/hdr_flag_capture.sv
module hdr_flag_capture
  import hdr_pkg::*;
#(
  parameter int ENC_IDX = 69,
  parameter int CMP_IDX = 229,
  parameter int CW      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sop_i,
  input  logic          beat_i,
  input  logic          last_i,
  input  logic [CW-1:0] idx_i,
  input  logic [1:0]    enc_field_i,
  input  logic          cmp_bit_i,
  input  logic          wide_i,
  output logic [1:0]    ratio_o,
  output logic          ratio_valid_o,
  output logic          encrypted_o,
  output logic          compressed_o,
  output logic          hdr_err_o
);
  logic enc_seen;
  logic hit_enc, hit_cmp, short_end, open_img;

  assign open_img  = sop_i || (!ratio_valid_o && !hdr_err_o);
  assign hit_enc   = beat_i && (idx_i == CW'(ENC_IDX)) && open_img;
  assign hit_cmp   = beat_i && (idx_i == CW'(CMP_IDX)) && open_img;
  assign short_end = beat_i && last_i && (idx_i < CW'(CMP_IDX)) && open_img;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enc_seen      <= 1'b0;
      ratio_o       <= 2'd0;
      ratio_valid_o <= 1'b0;
      encrypted_o   <= 1'b0;
      compressed_o  <= 1'b0;
      hdr_err_o     <= 1'b0;
    end else begin
      if (hit_enc)    enc_seen <= (enc_field_i != 2'b00);
      else if (sop_i) enc_seen <= 1'b0;

      if (hit_cmp) begin
        ratio_valid_o <= 1'b1;
        ratio_o       <= ratio_code(enc_seen, !cmp_bit_i, wide_i);
        encrypted_o   <= enc_seen;
        compressed_o  <= !cmp_bit_i;
      end else if (sop_i) begin
        ratio_valid_o <= 1'b0;
        ratio_o       <= 2'd0;
        encrypted_o   <= 1'b0;
        compressed_o  <= 1'b0;
      end

      if (short_end)  hdr_err_o <= 1'b1;
      else if (sop_i) hdr_err_o <= 1'b0;
    end
  end

  // R5: a valid result holds until the next start pulse
  assert_result_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_valid_o && !sop_i) |=> (ratio_valid_o && $stable(ratio_o)));
  // R6: an image never carries both an error and a result
  assert_err_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(hdr_err_o && ratio_valid_o));
  // R3: code 0 only for a plain image
  assert_zero_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_valid_o |-> ((ratio_o == 2'd0) == (!encrypted_o && !compressed_o)));
  // R4: a compressed image never gets a code below 2
  assert_cmp_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_valid_o && compressed_o) |-> (ratio_o >= 2'd2));
  // R7: a start pulse clears both result and error
  assert_sop_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sop_i && !beat_i) |=> (!ratio_valid_o && !hdr_err_o));

endmodule

// File: rtl/hdr_tail_pass.sv
module hdr_tail_pass
  import hdr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          in_last,
  input  logic [1:0]    in_bytes,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  logic [DW-1:0] keep;

  assign keep = in_last ? DW'(tail_mask(in_bytes)) : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data & keep;
    end
  end

  // R8: output valid follows input valid by one cycle
  assert_valid_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R9: a one-byte tail leaves the upper bytes zero
  assert_tail_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last && in_bytes == 2'd1) |=> (out_data[DW-1:8] == '0));

endmodule

// File: rtl/hdr_ratio_detect.sv
module hdr_ratio_detect #(
  parameter int ENC_IDX = 69,
  parameter int CMP_IDX = 229,
  localparam int LIMIT = CMP_IDX + 1,
  localparam int CW    = $clog2(LIMIT + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sop_i,
  input  logic        wide_i,
  input  logic        in_valid,
  input  logic [31:0] in_data,
  input  logic        in_last,
  input  logic [1:0]  in_bytes,
  output logic        out_valid,
  output logic [31:0] out_data,
  output logic [1:0]  ratio_o,
  output logic        ratio_valid_o,
  output logic        encrypted_o,
  output logic        compressed_o,
  output logic        hdr_err_o
);
  logic [CW-1:0] beat_idx;

  hdr_beat_counter #(.LIMIT(LIMIT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .sop_i(sop_i), .beat_i(in_valid),
    .idx_o(beat_idx)
  );

  hdr_flag_capture #(.ENC_IDX(ENC_IDX), .CMP_IDX(CMP_IDX), .CW(CW)) u_cap (
    .clk(clk), .rst_n(rst_n), .sop_i(sop_i), .beat_i(in_valid),
    .last_i(in_last), .idx_i(beat_idx), .enc_field_i(in_data[3:2]),
    .cmp_bit_i(in_data[1]), .wide_i(wide_i), .ratio_o(ratio_o),
    .ratio_valid_o(ratio_valid_o), .encrypted_o(encrypted_o),
    .compressed_o(compressed_o), .hdr_err_o(hdr_err_o)
  );

  hdr_tail_pass #(.DW(32)) u_pass (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_bytes(in_bytes), .out_valid(out_valid),
    .out_data(out_data)
  );

endmodule

// File: tb/tb_hdr_ratio_detect.sv
module tb_hdr_ratio_detect;
  logic clk = 1'b0, rst_n = 1'b0, sop = 1'b0, wide = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [31:0] in_data = '0;
  logic [1:0]  in_bytes = '0;
  logic out_valid, ratio_valid, encrypted, compressed, hdr_err;
  logic [31:0] out_data;
  logic [1:0]  ratio;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  hdr_ratio_detect dut (
    .clk(clk), .rst_n(rst_n), .sop_i(sop), .wide_i(wide),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_bytes(in_bytes), .out_valid(out_valid), .out_data(out_data),
    .ratio_o(ratio), .ratio_valid_o(ratio_valid), .encrypted_o(encrypted),
    .compressed_o(compressed), .hdr_err_o(hdr_err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] word_of(input int i, input bit [1:0] e,
                                          input bit c);
    logic [31:0] w;
    w = {i[15:0] ^ 16'h5a5a, ~i[15:0]};
    if (i == 69)  w[3:2] = e;
    if (i == 229) w[1] = c;
    return w;
  endfunction

  // Expected code from the clock multiplier: x1, x2, x4, x8 -> 0..3
  function automatic logic [1:0] exp_code(input bit enc, input bit cmp,
                                          input bit w);
    int mult;
    mult = 1;
    if (cmp)      mult = w ? 8 : 4;
    else if (enc) mult = w ? 4 : 2;
    return (mult == 8) ? 2'd3 : (mult == 4) ? 2'd2 : (mult == 2) ? 2'd1 : 2'd0;
  endfunction

  function automatic logic [31:0] trim(input logic [31:0] w, input bit [1:0] n);
    if (n == 2'd1) return w & 32'h0000_00ff;
    if (n == 2'd2) return w & 32'h0000_ffff;
    if (n == 2'd3) return w & 32'h00ff_ffff;
    return w;
  endfunction

  task automatic pulse_sop();
    @(negedge clk); sop = 1'b1;
    @(negedge clk); sop = 1'b0;
  endtask

  task automatic test_reset();
    check(!out_valid && out_data == 0 && ratio == 0 && !ratio_valid &&
          !encrypted && !compressed && !hdr_err, "R10", "outputs after reset",
          {out_valid, ratio_valid, encrypted, compressed, hdr_err, ratio},
          32'h0);
  endtask

  // Stream n words; word 69 carries e in [3:2], word 229 carries c in bit 1
  task automatic run_image(input int n, input bit [1:0] e, input bit c,
                           input bit w, input bit [1:0] tail, input string req);
    int mism;
    logic [31:0] exp;
    bit enc, cmp;
    mism = 0;
    pulse_sop();
    @(negedge clk);
    check(!ratio_valid && !hdr_err, "R7", "cleared after start",
          {ratio_valid, hdr_err}, 32'h0);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = word_of(i, e, c);
      in_last  = (i == n - 1);
      in_bytes = (i == n - 1) ? tail : 2'd0;
      wide     = w;
      @(posedge clk); #1;
      exp = (i == n - 1) ? trim(word_of(i, e, c), tail) : word_of(i, e, c);
      if (!out_valid || out_data !== exp) mism++;
      if (i == 228 && n > 229)
        check(!ratio_valid, "R5", "no result before word 229", ratio_valid, 0);
      if (i == 229)
        check(ratio_valid, "R5", "result after word 229", ratio_valid, 1);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; in_bytes = 2'd0;
    wide = ~w;
    repeat (3) @(negedge clk);
    check(mism == 0, (tail != 0) ? "R9" : "R8", "pass-through mismatches",
          mism, 0);
    check(!out_valid, "R8", "idle output valid", out_valid, 0);
    enc = (e != 2'b00);
    cmp = !c;
    if (n > 229) begin
      check(ratio_valid && ratio == exp_code(enc, cmp, w), req, "ratio code",
            {ratio_valid, ratio}, {1'b1, exp_code(enc, cmp, w)});
      check(encrypted == enc, "R1", "encrypted flag", encrypted, enc);
      check(compressed == cmp, "R2", "compressed flag", compressed, cmp);
      check(!hdr_err, "R6", "no header error", hdr_err, 0);
    end else begin
      check(hdr_err, "R6", "header error on short image", hdr_err, 1);
      check(!ratio_valid, "R6", "no result on short image", ratio_valid, 0);
    end
  endtask

  // Abandoned header: word 69 encrypted, then cut off by a new start
  task automatic test_abort();
    pulse_sop();
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = word_of(i, 2'b11, 1'b0);
    end
    @(negedge clk); in_valid = 1'b0;
    run_image(232, 2'b00, 1'b1, 1'b1, 2'd0, "R7");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    run_image(232, 2'b00, 1'b1, 1'b0, 2'd0, "R3");
    run_image(232, 2'b00, 1'b1, 1'b1, 2'd0, "R3");
    run_image(232, 2'b00, 1'b0, 1'b0, 2'd0, "R4");
    run_image(232, 2'b00, 1'b0, 1'b1, 2'd0, "R4");
    run_image(232, 2'b01, 1'b1, 1'b0, 2'd0, "R4");
    run_image(232, 2'b10, 1'b1, 1'b1, 2'd0, "R4");
    run_image(232, 2'b11, 1'b0, 1'b0, 2'd0, "R4");
    run_image(232, 2'b11, 1'b0, 1'b1, 2'd0, "R4");
    run_image(229, 2'b01, 1'b0, 1'b1, 2'd0, "R6");
    run_image(230, 2'b01, 1'b0, 1'b1, 2'd0, "R6");
    run_image(231, 2'b00, 1'b1, 1'b0, 2'd1, "R9");
    run_image(231, 2'b00, 1'b1, 1'b0, 2'd2, "R9");
    run_image(231, 2'b00, 1'b1, 1'b0, 2'd3, "R9");
    test_abort();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule